// File: doc/BRIEF.md
# Single-Transfer Parallel Bus Initiator

This block is the initiating side of a 32-bit multiplexed address/data shared bus of the PCI kind. It carries out one read or one write per request. Local logic presents an address, a four-bit command code, byte enables and, for writes, a data word. The block then runs the bus protocol: an address phase, a turnaround clock on reads, and a data phase that is stretched for as long as the target holds off its ready strobe. It reports completion with a one-cycle acknowledge and a status bit.

If no target claims the cycle within a fixed number of clocks after the address phase, the block ends the transaction with a master abort. Each tri-state line appears as a value output and a separate enable output. The cycle-start and initiator-ready strobes share one enable, which stays high from the address phase through one release clock. Bursts, arbitration, parity and retry are not part of this block.

Top module: `pcisc_initiator`

## Requirements
- R1: After reset, and whenever no transaction is running, every bus enable (`ctlOe`, `adOe`, `cbeOe`) is low and `reqAck` is low.
- R2: A request is sampled only while the block is idle. `reqValid` held high during a running transaction starts no further transaction.
- R3: The clock after a request is accepted is the address phase. `cycStartN` is 0, `mstRdyN` is 1, `adOut` carries the request address and `cbeOut` carries the command code, with all enables high.
- R4: In a write data phase, `cycStartN` is 1 and `mstRdyN` is 0. `adOut` carries the write word and `cbeOut` carries the inverse of `reqByteEn`, so that bit i low enables byte lane i.
- R5: A read leaves exactly one turnaround clock after the address phase. In it `adOe` is 0, `cycStartN` stays 0, `mstRdyN` stays 1 and `cbeOut` already carries the byte enables. Target ready in that clock moves no data.
- R6: While the target has claimed the cycle but `tgtRdyN` is 1, the data phase holds with unchanged outputs.
- R7: Data moves on the first edge in the data phase where both `tgtClaimN` and `tgtRdyN` are 0. A read stores `adIn` into `rdData`, which then holds until the next read completes.
- R8: If `tgtClaimN` is not sampled low on any of the 6 edges after the address phase, the transaction ends with status 1 (master abort). A claim on the 6th edge avoids the abort.
- R9: Every transaction ends with one release clock in which `ctlOe` is 1, both strobes are 1 and `adOe`/`cbeOe` are 0. The clock after that is idle.
- R10: `reqAck` is high for exactly the release clock. `ackStatus` is 0 for a completed transfer and 1 for a master abort.
- R11: Bit 0 of the command code selects direction: 0 is a read (turnaround, AD not driven in the data phase) and 1 is a write (AD driven, no turnaround).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present (sampled when idle) |
| reqAddr | input | 32 | Transaction address |
| reqCmd | input | 4 | Command code; bit 0 set means write |
| reqByteEn | input | 4 | Active-high byte lane enables |
| reqWrData | input | 32 | Write data word |
| reqAck | output | 1 | One-cycle completion pulse |
| ackStatus | output | 1 | 0 = transferred, 1 = master abort |
| rdData | output | 32 | Last read word |
| cycStartN | output | 1 | Cycle-start strobe, active low |
| mstRdyN | output | 1 | Initiator-ready strobe, active low |
| ctlOe | output | 1 | Enable for both strobes |
| adOut | output | 32 | Address/data value driven |
| adOe | output | 1 | Address/data enable |
| adIn | input | 32 | Address/data value seen on the bus |
| cbeOut | output | 4 | Command / byte-enable value driven |
| cbeOe | output | 1 | Command / byte-enable enable |
| tgtClaimN | input | 1 | Target claim strobe, active low |
| tgtRdyN | input | 1 | Target ready strobe, active low |

## Verification
A request accepted at one edge shows its address phase in the following clock. A write's data phase follows one clock later, and a read's data phase two clocks later because of the turnaround. The acknowledge appears in the clock after the transferring edge, and the abort appears in the clock after the sixth post-address edge, seven clocks after acceptance. The bench drives inputs and samples outputs on falling edges and counts these clocks explicitly in each scenario. Target strobes are set before the exact rising edge that must, or must not, see them, including the boundary where the claim arrives on the last permitted edge.

// File: rtl/pcisc_pkg.sv
package pcisc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_TURN,
    ST_DATA,
    ST_REL
  } phase_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic loadReq;    // latch the local request
    logic capture;    // store read word from the bus
    logic adDrive;    // enable AD drivers
    logic adSelAddr;  // AD carries address (else write data)
    logic cbeDrive;   // enable C/BE drivers
    logic cbeSelCmd;  // C/BE carries command (else byte enables)
  } strobe_t;

  localparam logic STAT_OK    = 1'b0;
  localparam logic STAT_ABORT = 1'b1;

endpackage

// File: rtl/pcisc_ctrl.sv
module pcisc_ctrl
  import pcisc_pkg::*;
#(
  parameter int CLAIM_LIMIT = 6
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqIsRead,
  input  logic    tgtClaimN,
  input  logic    tgtRdyN,
  output strobe_t stb,
  output logic    cycStartN,
  output logic    mstRdyN,
  output logic    ctlOe,
  output logic    reqAck,
  output logic    ackStatus
);

  localparam int CNT_W = $clog2(CLAIM_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(CLAIM_LIMIT - 1);

  phase_e           state, nextState;
  logic [CNT_W-1:0] waitCnt;
  logic             claimedQ;
  logic             isReadQ;
  logic             abortQ;
  logic             postAddr;
  logic             timeout;
  logic             xfer;

  assign postAddr = (state == ST_TURN) || (state == ST_DATA);
  assign timeout  = postAddr && !claimedQ && tgtClaimN && (waitCnt == LAST_WAIT);
  assign xfer     = (state == ST_DATA) && !tgtClaimN && !tgtRdyN;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: if (reqValid) nextState = ST_ADDR;
      ST_ADDR: nextState = isReadQ ? ST_TURN : ST_DATA;
      ST_TURN: nextState = timeout ? ST_REL : ST_DATA;
      ST_DATA: if (xfer || timeout) nextState = ST_REL;
      ST_REL:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      waitCnt  <= '0;
      claimedQ <= 1'b0;
      isReadQ  <= 1'b0;
      abortQ   <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && reqValid) begin
        isReadQ <= reqIsRead;
        abortQ  <= 1'b0;
      end
      if (state == ST_ADDR) begin
        waitCnt  <= '0;
        claimedQ <= 1'b0;
      end else if (postAddr) begin
        if (!tgtClaimN) claimedQ <= 1'b1;
        if (waitCnt != LAST_WAIT) waitCnt <= waitCnt + 1'b1;
        if (timeout) abortQ <= 1'b1;
      end
    end
  end

  always_comb begin
    stb.loadReq   = (state == ST_IDLE) && reqValid;
    stb.capture   = xfer && isReadQ;
    stb.adDrive   = (state == ST_ADDR) || ((state == ST_DATA) && !isReadQ);
    stb.adSelAddr = (state == ST_ADDR);
    stb.cbeDrive  = (state == ST_ADDR) || postAddr;
    stb.cbeSelCmd = (state == ST_ADDR);
  end

  assign ctlOe     = (state != ST_IDLE);
  assign cycStartN = !((state == ST_ADDR) || (state == ST_TURN));
  assign mstRdyN   = (state != ST_DATA);
  assign reqAck    = (state == ST_REL);
  assign ackStatus = abortQ ? STAT_ABORT : STAT_OK;

  // R9: release lasts one clock and is followed by idle
  p_release_then_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REL) |=> (state == ST_IDLE));

  // R2: while busy the request input cannot restart the address phase
  p_no_accept_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |=> (state != ST_ADDR));

endmodule

// File: rtl/pcisc_dpath.sv
module pcisc_dpath
  import pcisc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CMD_W  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [DATA_W-1:0]     reqAddr,
  input  logic [CMD_W-1:0]      reqCmd,
  input  logic [DATA_W/8-1:0]   reqByteEn,
  input  logic [DATA_W-1:0]     reqWrData,
  input  logic [DATA_W-1:0]     adIn,
  output logic [DATA_W-1:0]     adOut,
  output logic                  adOe,
  output logic [DATA_W/8-1:0]   cbeOut,
  output logic                  cbeOe,
  output logic [DATA_W-1:0]     rdData
);

  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] addrQ, wrQ;
  logic [CMD_W-1:0]  cmdQ;
  logic [LANES-1:0]  beQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wrQ    <= '0;
      cmdQ   <= '0;
      beQ    <= '0;
      rdData <= '0;
    end else begin
      if (stb.loadReq) begin
        addrQ <= reqAddr;
        wrQ   <= reqWrData;
        cmdQ  <= reqCmd;
        beQ   <= reqByteEn;
      end
      if (stb.capture) rdData <= adIn;
    end
  end

  assign adOut  = stb.adSelAddr ? addrQ : wrQ;
  assign adOe   = stb.adDrive;
  assign cbeOut = stb.cbeSelCmd ? LANES'(cmdQ) : ~beQ;
  assign cbeOe  = stb.cbeDrive;

  // R7: the read word holds between captures
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capture |=> $stable(rdData));

endmodule

// File: rtl/pcisc_initiator.sv
module pcisc_initiator
  import pcisc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CMD_W       = 4,
  parameter int CLAIM_LIMIT = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [DATA_W-1:0]   reqAddr,
  input  logic [CMD_W-1:0]    reqCmd,
  input  logic [DATA_W/8-1:0] reqByteEn,
  input  logic [DATA_W-1:0]   reqWrData,
  output logic                reqAck,
  output logic                ackStatus,
  output logic [DATA_W-1:0]   rdData,
  output logic                cycStartN,
  output logic                mstRdyN,
  output logic                ctlOe,
  output logic [DATA_W-1:0]   adOut,
  output logic                adOe,
  input  logic [DATA_W-1:0]   adIn,
  output logic [DATA_W/8-1:0] cbeOut,
  output logic                cbeOe,
  input  logic                tgtClaimN,
  input  logic                tgtRdyN
);

  strobe_t stb;

  pcisc_ctrl #(.CLAIM_LIMIT(CLAIM_LIMIT)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqIsRead (!reqCmd[0]),
    .tgtClaimN (tgtClaimN),
    .tgtRdyN   (tgtRdyN),
    .stb       (stb),
    .cycStartN (cycStartN),
    .mstRdyN   (mstRdyN),
    .ctlOe     (ctlOe),
    .reqAck    (reqAck),
    .ackStatus (ackStatus)
  );

  pcisc_dpath #(.DATA_W(DATA_W), .CMD_W(CMD_W)) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqAddr   (reqAddr),
    .reqCmd    (reqCmd),
    .reqByteEn (reqByteEn),
    .reqWrData (reqWrData),
    .adIn      (adIn),
    .adOut     (adOut),
    .adOe      (adOe),
    .cbeOut    (cbeOut),
    .cbeOe     (cbeOe),
    .rdData    (rdData)
  );

  // R3: first driven clock is an address phase
  p_addr_phase_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctlOe) |-> (!cycStartN && mstRdyN && adOe && cbeOe));

  // R5: turnaround clock is followed by an undriven read data phase
  p_turnaround_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctlOe && !cycStartN && mstRdyN && !adOe) |=> (cycStartN && !mstRdyN && !adOe));

  // R6: claimed but not ready keeps the data phase
  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!mstRdyN && !tgtClaimN && tgtRdyN) |=> !mstRdyN);

  // R7/R10: both ready strobes low completes with OK status next clock
  p_transfer_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!mstRdyN && !tgtClaimN && !tgtRdyN) |=> (reqAck && ackStatus == STAT_OK));

  // R10: acknowledge is a single pulse
  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

  // R1/R9: after acknowledge all enables are off
  p_quiet_after_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> (!ctlOe && !adOe && !cbeOe));

endmodule

// File: tb/test_pcisc_initiator.sv
module test_pcisc_initiator;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [3:0]  reqCmd = '0;
  logic [3:0]  reqByteEn = '0;
  logic [31:0] reqWrData = '0;
  logic        reqAck, ackStatus;
  logic [31:0] rdData;
  logic        cycStartN, mstRdyN, ctlOe;
  logic [31:0] adOut;
  logic        adOe;
  logic [31:0] adIn = '0;
  logic [3:0]  cbeOut;
  logic        cbeOe;
  logic        tgtClaimN = 1'b1;
  logic        tgtRdyN = 1'b1;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pcisc_initiator i_pcisc_initiator (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqCmd(reqCmd), .reqByteEn(reqByteEn), .reqWrData(reqWrData),
    .reqAck(reqAck), .ackStatus(ackStatus), .rdData(rdData),
    .cycStartN(cycStartN), .mstRdyN(mstRdyN), .ctlOe(ctlOe),
    .adOut(adOut), .adOe(adOe), .adIn(adIn), .cbeOut(cbeOut),
    .cbeOe(cbeOe), .tgtClaimN(tgtClaimN), .tgtRdyN(tgtRdyN)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic targetIdle();
    tgtClaimN = 1'b1;
    tgtRdyN   = 1'b1;
  endtask

  // Ends at the falling edge inside the address phase
  task automatic issue(input logic [31:0] a, input logic [3:0] c,
                       input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqCmd = c; reqByteEn = be; reqWrData = wd;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic checkQuiet(input string req);
    chk(req, "ctlOe", 32'(ctlOe), 32'd0);
    chk(req, "adOe", 32'(adOe), 32'd0);
    chk(req, "cbeOe", 32'(cbeOe), 32'd0);
    chk(req, "reqAck", 32'(reqAck), 32'd0);
  endtask

  task automatic testReset();
    @(negedge clk);
    checkQuiet("R1");
  endtask

  task automatic testWriteFast();
    issue(32'h1000_0040, 4'b0111, 4'b0101, 32'hCAFE_0001);
    chk("R3", "start", 32'(cycStartN), 32'd0);
    chk("R3", "irdy", 32'(mstRdyN), 32'd1);
    chk("R3", "adOut", adOut, 32'h1000_0040);
    chk("R3", "adOe", 32'(adOe), 32'd1);
    chk("R3", "cbeOut", 32'(cbeOut), 32'h7);
    chk("R3", "cbeOe", 32'(cbeOe), 32'd1);
    tgtClaimN = 1'b0; tgtRdyN = 1'b0;
    @(negedge clk);
    chk("R4", "start", 32'(cycStartN), 32'd1);
    chk("R4", "irdy", 32'(mstRdyN), 32'd0);
    chk("R4", "adOut", adOut, 32'hCAFE_0001);
    chk("R11", "adOe write", 32'(adOe), 32'd1);
    chk("R4", "cbeOut", 32'(cbeOut), 32'hA);
    chk("R10", "no early ack", 32'(reqAck), 32'd0);
    @(negedge clk);
    targetIdle();
    chk("R10", "ack", 32'(reqAck), 32'd1);
    chk("R10", "status ok", 32'(ackStatus), 32'd0);
    chk("R9", "ctlOe rel", 32'(ctlOe), 32'd1);
    chk("R9", "strobes rel", {30'd0, cycStartN, mstRdyN}, 32'd3);
    chk("R9", "ad/cbe off", {30'd0, adOe, cbeOe}, 32'd0);
    @(negedge clk);
    checkQuiet("R9");
  endtask

  task automatic testWriteWaitBusy();
    issue(32'h2000_0000, 4'b0111, 4'b1111, 32'h1234_5678);
    tgtClaimN = 1'b0; tgtRdyN = 1'b1;
    reqValid = 1'b1; reqAddr = 32'hDEAD_0000; reqCmd = 4'b0110;
    @(negedge clk);
    chk("R6", "data phase", 32'(mstRdyN), 32'd0);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R6", "held irdy", 32'(mstRdyN), 32'd0);
    chk("R6", "held ad", adOut, 32'h1234_5678);
    chk("R6", "no ack", 32'(reqAck), 32'd0);
    @(negedge clk);
    chk("R6", "still held", 32'(mstRdyN), 32'd0);
    tgtRdyN = 1'b0;
    @(negedge clk);
    targetIdle();
    chk("R6", "ack after wait", 32'(reqAck), 32'd1);
    @(negedge clk);
    checkQuiet("R2");
    @(negedge clk);
    chk("R2", "no second cycle", 32'(ctlOe), 32'd0);
  endtask

  task automatic testRead();
    issue(32'h3000_0100, 4'b0110, 4'b1100, 32'h0);
    chk("R3", "read cmd", 32'(cbeOut), 32'h6);
    tgtClaimN = 1'b0; tgtRdyN = 1'b0;
    @(negedge clk);
    chk("R5", "ad released", 32'(adOe), 32'd0);
    chk("R5", "start held", 32'(cycStartN), 32'd0);
    chk("R5", "irdy off", 32'(mstRdyN), 32'd1);
    chk("R5", "byte enables", 32'(cbeOut), 32'h3);
    chk("R5", "cbeOe", 32'(cbeOe), 32'd1);
    @(negedge clk);
    chk("R5", "trdy ignored", 32'(reqAck), 32'd0);
    chk("R11", "read data phase", {30'd0, mstRdyN, adOe}, 32'd0);
    adIn = 32'h5A5A_1234;
    @(negedge clk);
    chk("R7", "ack", 32'(reqAck), 32'd1);
    chk("R7", "status", 32'(ackStatus), 32'd0);
    chk("R7", "rdData", rdData, 32'h5A5A_1234);
    targetIdle();
    adIn = 32'hFFFF_0000;
    @(negedge clk);
    @(negedge clk);
    chk("R7", "rdData held", rdData, 32'h5A5A_1234);
  endtask

  task automatic testAbortWrite();
    issue(32'h0000_0800, 4'b1011, 4'b1111, 32'h0BAD_F00D);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk("R8", "waiting", {30'd0, reqAck, mstRdyN}, 32'd0);
    end
    @(negedge clk);
    chk("R8", "abort ack", 32'(reqAck), 32'd1);
    chk("R8", "abort status", 32'(ackStatus), 32'd1);
    chk("R9", "abort release", {29'd0, ctlOe, adOe, cbeOe}, 32'd4);
    @(negedge clk);
    checkQuiet("R1");
  endtask

  task automatic testAbortRead();
    issue(32'h0000_0CF8, 4'b0010, 4'b0001, 32'h0);
    @(negedge clk);
    chk("R11", "io read turnaround", {30'd0, adOe, mstRdyN}, 32'd1);
    for (int k = 2; k <= 6; k++) begin
      @(negedge clk);
      chk("R8", "read waiting", 32'(reqAck), 32'd0);
    end
    @(negedge clk);
    chk("R8", "read abort", {30'd0, reqAck, ackStatus}, 32'd3);
  endtask

  task automatic testLateClaim();
    issue(32'h4000_0010, 4'b0111, 4'b0011, 32'h7777_8888);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk("R8", "late waiting", 32'(reqAck), 32'd0);
      if (k == 6) begin
        tgtClaimN = 1'b0; tgtRdyN = 1'b0;
      end
    end
    @(negedge clk);
    targetIdle();
    chk("R8", "late claim ok", {30'd0, reqAck, ackStatus}, 32'd2);
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWriteFast();
    testWriteWaitBusy();
    testRead();
    testAbortWrite();
    testAbortRead();
    testLateClaim();
    finishRun();
  end

  initial begin
    repeat (5000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

endmodule